// File: doc/BRIEF.md
# Eight-Channel Edge-Aligned PWM Timer

This block produces eight pulse-width-modulated outputs from a single shared up-counter. Software programs the block through a small word-addressed register port. The counter runs from a programmable start value up to a programmable top value and then reloads. Its rate comes from one of three tick sources: the bus clock itself, or one of two slower sources that arrive as single-cycle enable pulses already synchronised to the bus clock. A power-of-two prescaler divides the selected source. Because every channel sees the same counter, all channels share one period. Each channel differs only in its compare value, its output inversion, its mask and its enable.

Each channel in PWM mode holds a raw level that is high while the counter is below the channel's compare value. The raw level is then inverted where the polarity bit asks for it. Masked or disabled channels sit at their inactive level, which is the polarity bit itself. A write to the counter register restarts the count and loads every raw level from an initial-level register.

A protection latch guards the configuration registers. The latch is armed at reset. While it is armed, period, clock, channel mode, polarity and initial-level writes are dropped, but compare values and the mask stay writable, so duty cycles can be changed without unlocking.

Top module: `pwm8_timer`

## Requirements
- R1: After reset the counter reads 0, the clock source is stopped, the top value reads 0xFFFF, the mask register (0x60) reads 0xFF, protection is armed and every output is 0.
- R2: Control register 0x00 bits 4:3 choose the tick source (0 none, 1 every bus cycle, 2 `fix_tick` pulses, 3 `ext_tick` pulses) and bits 2:0 give a prescale exponent ps, so the counter advances once per 2^ps source ticks.
- R3: The counter counts up from the start value (0x4C) to the top value (0x08) inclusive and then reloads the start value, so the period is (top+1-start)·2^ps source ticks.
- R4: Channel n is in PWM mode when bits 5 and 3 of its mode register (0x0C+8n) are both 1. Its raw level is high while the counter is below its compare value (0x10+8n), so a compare value at or below the start value gives a constant low and a compare value above the top value gives a constant high. A channel not in PWM mode drives its inactive level.
- R5: Bit n of the polarity register (0x70) inverts channel n's output, and it is also that channel's inactive level.
- R6: Bit n of the mask register (0x60) forces channel n to its inactive level.
- R7: Control register bits 16+n enable channel n (reset 0). A channel whose enable bit is 0 drives its inactive level.
- R8: While protection is armed, writes to the control, top, start, channel mode, polarity and initial-level registers are ignored, and writes to compare values and the mask still take effect.
- R9: Writing 1 to bit 2 of register 0x54 disarms protection. Writing 1 to bit 6 of register 0x74 arms it, and bit 6 of 0x74 reads the armed state.
- R10: Any write to the counter register (0x04) loads the start value into the counter, clears the prescaler and loads each raw level from bit n of the initial-level register (0x5C). A read of 0x04 returns the live counter.
- R11: With tick source 0 the counter and every raw level hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of a 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fix_tick | input | 1 | One-cycle tick pulse of the fixed source |
| ext_tick | input | 1 | One-cycle tick pulse of the external source |
| pwm_out | output | 8 | Channel outputs after mode, enable, mask and polarity |

## Verification
A register write lands on the rising edge where bus_wr is high. Its value shows on the read port, and through mask, enable, polarity and mode on pwm_out, from the following falling edge on. Raw levels and the counter move only on the rising edges where the prescaled tick fires, so duty checks count high cycles on falling-edge samples over a window of exactly four whole periods. That count does not depend on phase. Counter-rate checks compare two reads taken a known number of cycles apart. Reload checks sample one read per cycle and predict each value from the one before.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_COUNT  = 8'h04;
  localparam logic [7:0] A_TOP    = 8'h08;
  localparam logic [7:0] A_CHCFG0 = 8'h0C;
  localparam logic [7:0] A_CMP0   = 8'h10;
  localparam logic [7:0] A_START  = 8'h4C;
  localparam logic [7:0] A_MODE   = 8'h54;
  localparam logic [7:0] A_INIT   = 8'h5C;
  localparam logic [7:0] A_MASK   = 8'h60;
  localparam logic [7:0] A_INVERT = 8'h70;
  localparam logic [7:0] A_GUARD  = 8'h74;

  localparam int UNLOCK_BIT = 2;
  localparam int LOCK_BIT   = 6;
  localparam int CH_STRIDE  = 8;
  localparam int EN_LSB     = 16;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } src_e;

  function automatic logic [7:0] chcfg_addr(int n);
    return A_CHCFG0 + 8'(CH_STRIDE * n);
  endfunction

  function automatic logic [7:0] cmp_addr(int n);
    return A_CMP0 + 8'(CH_STRIDE * n);
  endfunction

  // terminal value of the prescale counter: 2^ps - 1
  function automatic logic [6:0] ps_limit(logic [2:0] ps);
    return 7'((8'd1 << ps) - 8'd1);
  endfunction

  function automatic logic src_pulse(src_e s, logic fix, logic ext);
    case (s)
      SRC_SYS: return 1'b1;
      SRC_FIX: return fix;
      SRC_EXT: return ext;
      default: return 1'b0;
    endcase
  endfunction

  // edge-aligned, high-true compare mode needs both mode bits
  function automatic logic edge_mode(logic [5:0] cfg);
    return cfg[5] & cfg[3];
  endfunction

endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs
  import pwm8_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int CW        = 16,
  parameter bit HAS_CH_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  input  logic [CW-1:0]           cnt_i,
  output logic [31:0]             bus_rdata,
  output logic [2:0]              ps_o,
  output src_e                    src_o,
  output logic [NCH-1:0]          en_o,
  output logic [CW-1:0]           top_o,
  output logic [CW-1:0]           start_o,
  output logic [NCH-1:0][CW-1:0]  cmp_o,
  output logic [NCH-1:0][5:0]     cfg_o,
  output logic [NCH-1:0]          pol_o,
  output logic [NCH-1:0]          init_o,
  output logic [NCH-1:0]          mask_o,
  output logic                    locked_o,
  output logic                    cnt_init_o
);

  logic [2:0]             ps_q;
  src_e                   src_q;
  logic [NCH-1:0]         en_q;
  logic [CW-1:0]          top_q, start_q;
  logic [NCH-1:0][CW-1:0] cmp_q;
  logic [NCH-1:0][5:0]    cfg_q;
  logic [NCH-1:0]         pol_q, init_q, mask_q;
  logic                   locked_q;
  logic                   wr_cfg;
  logic                   unused_wbits;

  assign wr_cfg       = bus_wr && !locked_q;
  assign unused_wbits = ^{bus_wdata, bus_addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q     <= '0;
      src_q    <= SRC_OFF;
      top_q    <= '1;
      start_q  <= '0;
      cmp_q    <= '0;
      cfg_q    <= '0;
      pol_q    <= '0;
      init_q   <= '0;
      mask_q   <= '1;
      locked_q <= 1'b1;
    end else begin
      if (wr_cfg) begin
        if (bus_addr == A_CTRL) begin
          ps_q  <= bus_wdata[2:0];
          src_q <= src_e'(bus_wdata[4:3]);
        end
        if (bus_addr == A_TOP)    top_q   <= bus_wdata[CW-1:0];
        if (bus_addr == A_START)  start_q <= bus_wdata[CW-1:0];
        if (bus_addr == A_INVERT) pol_q   <= bus_wdata[NCH-1:0];
        if (bus_addr == A_INIT)   init_q  <= bus_wdata[NCH-1:0];
        for (int n = 0; n < NCH; n++)
          if (bus_addr == chcfg_addr(n)) cfg_q[n] <= bus_wdata[5:0];
      end
      if (bus_wr) begin
        if (bus_addr == A_MASK) mask_q <= bus_wdata[NCH-1:0];
        for (int n = 0; n < NCH; n++)
          if (bus_addr == cmp_addr(n)) cmp_q[n] <= bus_wdata[CW-1:0];
      end
      if (bus_wr && bus_addr == A_GUARD && bus_wdata[LOCK_BIT])
        locked_q <= 1'b1;
      else if (bus_wr && bus_addr == A_MODE && bus_wdata[UNLOCK_BIT])
        locked_q <= 1'b0;
    end
  end

  generate
    if (HAS_CH_EN) begin : g_en
      always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= '0;
        else if (wr_cfg && bus_addr == A_CTRL) en_q <= bus_wdata[EN_LSB +: NCH];
      end
    end else begin : g_noen
      assign en_q = '1;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[2:0]          = ps_q;
        bus_rdata[4:3]          = src_q;
        bus_rdata[EN_LSB +: NCH] = en_q;
      end
      A_COUNT:  bus_rdata[CW-1:0]  = cnt_i;
      A_TOP:    bus_rdata[CW-1:0]  = top_q;
      A_START:  bus_rdata[CW-1:0]  = start_q;
      A_INIT:   bus_rdata[NCH-1:0] = init_q;
      A_MASK:   bus_rdata[NCH-1:0] = mask_q;
      A_INVERT: bus_rdata[NCH-1:0] = pol_q;
      A_GUARD:  bus_rdata[LOCK_BIT] = locked_q;
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == cmp_addr(n))   bus_rdata[CW-1:0] = cmp_q[n];
      if (bus_addr == chcfg_addr(n)) bus_rdata[5:0]    = cfg_q[n];
    end
  end

  assign ps_o       = ps_q;
  assign src_o      = src_q;
  assign en_o       = en_q;
  assign top_o      = top_q;
  assign start_o    = start_q;
  assign cmp_o      = cmp_q;
  assign cfg_o      = cfg_q;
  assign pol_o      = pol_q;
  assign init_o     = init_q;
  assign mask_o     = mask_q;
  assign locked_o   = locked_q;
  assign cnt_init_o = bus_wr && (bus_addr == A_COUNT);

  // R8: an armed latch drops a period write
  assert_guard_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && locked_q && bus_addr == A_TOP) |=> $stable(top_q));

  // R8: compare values stay writable while armed
  assert_cmp_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && locked_q && bus_addr == cmp_addr(0))
      |=> cmp_q[0] == $past(bus_wdata[CW-1:0]));

  // R9: the disarm write leaves the latch open
  assert_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MODE && bus_wdata[UNLOCK_BIT]) |=> !locked_q);

endmodule

// File: rtl/pwm8_timebase.sv
module pwm8_timebase
  import pwm8_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  src_e          src,
  input  logic [2:0]    ps,
  input  logic          fix_tick,
  input  logic          ext_tick,
  input  logic [CW-1:0] top,
  input  logic [CW-1:0] start,
  input  logic          cnt_init,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          tick
);

  localparam int PW = 7;

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          src_p;
  logic          wrap;

  assign src_p   = src_pulse(src, fix_tick, ext_tick);
  assign tick    = src_p && (pre_q >= ps_limit(ps));
  assign wrap    = cnt_q >= top;
  assign cnt_nxt = wrap ? start : cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (cnt_init) begin
      pre_q <= '0;
      cnt_q <= start;
    end else if (src_p) begin
      pre_q <= tick ? '0 : pre_q + PW'(1);
      if (tick) cnt_q <= cnt_nxt;
    end
  end

  assign cnt = cnt_q;

  // R11: no source selected, nothing moves
  assert_stop_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_OFF && !cnt_init) |=> $stable(cnt_q));

  // R3: a tick at or past the top value lands on the start value
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_init && cnt_q >= top) |=> cnt_q == $past(start));

  // R10: a counter write restarts the count
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_init |=> cnt_q == $past(start));

  // R2: at most one step per source tick
  assert_one_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_p && !cnt_init) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel
  import pwm8_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_init,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] cmp,
  input  logic [5:0]    cfg,
  input  logic          pol,
  input  logic          mask,
  input  logic          en,
  input  logic          init_lvl,
  output logic          out
);

  logic raw_q;
  logic live;

  always_ff @(posedge clk) begin
    if (!rst_n)        raw_q <= 1'b0;
    else if (cnt_init) raw_q <= init_lvl;
    else if (tick)     raw_q <= cnt_nxt < cmp;
  end

  assign live = edge_mode(cfg) && en && !mask;
  assign out  = live ? (raw_q ^ pol) : pol;

  // R4: compare of zero never raises the raw level
  assert_zero_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_init && cmp == '0) |=> !raw_q);

  // R10: restart loads the initial level
  assert_init_lvl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_init |=> raw_q == $past(init_lvl));

  // R11: raw level frozen without a tick
  assert_raw_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_init) |=> $stable(raw_q));

endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
  import pwm8_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int CW        = 16,
  parameter bit HAS_CH_EN = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic           fix_tick,
  input  logic           ext_tick,
  output logic [NCH-1:0] pwm_out
);

  logic [2:0]             ps;
  src_e                   src;
  logic [NCH-1:0]         en, pol, init_lvl, mask;
  logic [CW-1:0]          top, start, cnt, cnt_nxt;
  logic [NCH-1:0][CW-1:0] cmp;
  logic [NCH-1:0][5:0]    cfg;
  logic                   locked, cnt_init, tick;

  pwm8_regs #(.NCH(NCH), .CW(CW), .HAS_CH_EN(HAS_CH_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_i(cnt), .bus_rdata(bus_rdata),
    .ps_o(ps), .src_o(src), .en_o(en), .top_o(top), .start_o(start),
    .cmp_o(cmp), .cfg_o(cfg), .pol_o(pol), .init_o(init_lvl),
    .mask_o(mask), .locked_o(locked), .cnt_init_o(cnt_init)
  );

  pwm8_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .src(src), .ps(ps),
    .fix_tick(fix_tick), .ext_tick(ext_tick), .top(top), .start(start),
    .cnt_init(cnt_init), .cnt(cnt), .cnt_nxt(cnt_nxt), .tick(tick)
  );

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      pwm8_channel #(.CW(CW)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_init(cnt_init),
        .cnt_nxt(cnt_nxt), .cmp(cmp[n]), .cfg(cfg[n]), .pol(pol[n]),
        .mask(mask[n]), .en(en[n]), .init_lvl(init_lvl[n]),
        .out(pwm_out[n])
      );
    end
  endgenerate

  // R6: a masked channel sits at its polarity level, checked at the pins
  assert_mask_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask[0]) |-> pwm_out[0] == pol[0]);

  // R8: armed latch keeps the source selection
  assert_guard_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_wr && bus_addr == A_CTRL) |=> $stable(src));

endmodule

// File: tb/sim_pwm8_timer.sv
module sim_pwm8_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        fix_tick = 1'b0;
  logic        ext_tick = 1'b0;
  logic [7:0]  pwm_out;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  int fix_per = 0;
  int ext_per = 0;
  int phase = 0;

  pwm8_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fix_tick(fix_tick),
    .ext_tick(ext_tick), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    phase = phase + 1;
    fix_tick = (fix_per != 0) && (phase % fix_per == 0);
    ext_tick = (ext_per != 0) && (phase % ext_per == 0);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_high(int cmp, int top, int start, int ps);
    int lvl;
    if (cmp <= start)   lvl = 0;
    else if (cmp > top) lvl = top + 1 - start;
    else                lvl = cmp - start;
    return lvl << ps;
  endfunction

  function automatic logic [7:0] exp_out(logic [7:0] raw, logic [7:0] pol,
                                         logic [7:0] mask, logic [7:0] en,
                                         logic [7:0] mode);
    logic [7:0] live;
    live = ~mask & en & mode;
    return ((raw ^ pol) & live) | (pol & ~live);
  endfunction

  function automatic logic [7:0] cfg_a(int n);  return 8'(12 + 8 * n); endfunction
  function automatic logic [7:0] cmp_a(int n);  return 8'(16 + 8 * n); endfunction

  logic [31:0] v, v2;
  int unsigned seed_sink;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    seed_sink = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    repeat (5) @(negedge clk);
    rd(8'h04, v);  chk("R1 counter", v, 32'h0);
    rd(8'h60, v);  chk("R1 mask", v, 32'hFF);
    rd(8'h08, v);  chk("R1 top", v, 32'hFFFF);
    rd(8'h74, v);  chk("R1 R9 armed", v, 32'h40);
    chk("R1 outputs", {24'h0, pwm_out}, 32'h0);
    repeat (10) @(negedge clk);
    rd(8'h04, v);  chk("R11 stopped at reset", v, 32'h0);

    // R8 armed latch
    wr(8'h08, 32'h20);   rd(8'h08, v); chk("R8 top ignored", v, 32'hFFFF);
    wr(cmp_a(0), 32'h5); rd(cmp_a(0), v); chk("R8 compare writable", v, 32'h5);
    wr(8'h60, 32'h0F);   rd(8'h60, v); chk("R8 mask writable", v, 32'h0F);
    wr(8'h70, 32'hFF);   rd(8'h70, v); chk("R8 polarity ignored", v, 32'h0);
    chk("R8 outputs untouched", {24'h0, pwm_out}, 32'h0);
    wr(cfg_a(3), 32'h28); rd(cfg_a(3), v); chk("R8 mode ignored", v, 32'h0);

    // R9 disarm
    wr(8'h54, 32'h4);
    rd(8'h74, v); chk("R9 disarmed", v, 32'h0);
    wr(8'h08, 32'h20); rd(8'h08, v); chk("R9 top now writable", v, 32'h20);

    // R10 initial level with counter stopped
    wr(8'h00, 32'h00FF_0000);
    for (int n = 0; n < 8; n++) wr(cfg_a(n), 32'h28);
    wr(8'h60, 32'h0); wr(8'h70, 32'h0); wr(8'h5C, 32'hA5); wr(8'h4C, 32'h0);
    wr(8'h04, 32'h0);
    @(negedge clk);
    chk("R10 init level", {24'h0, pwm_out}, 32'hA5);
    repeat (20) @(negedge clk);
    chk("R11 outputs held", {24'h0, pwm_out}, 32'hA5);
    rd(8'h04, v); chk("R11 counter held", v, 32'h0);

    // R5 polarity, R6 mask, R7 enable, R4 non-PWM mode
    wr(8'h70, 32'h0F); @(negedge clk);
    chk("R5 polarity", {24'h0, pwm_out}, {24'h0, exp_out(8'hA5, 8'h0F, 8'h00, 8'hFF, 8'hFF)});
    wr(8'h60, 32'hF0); @(negedge clk);
    chk("R6 mask", {24'h0, pwm_out}, {24'h0, exp_out(8'hA5, 8'h0F, 8'hF0, 8'hFF, 8'hFF)});
    wr(8'h60, 32'h0);
    wr(8'h00, 32'h000F_0000); @(negedge clk);
    chk("R7 enable", {24'h0, pwm_out}, {24'h0, exp_out(8'hA5, 8'h0F, 8'h00, 8'h0F, 8'hFF)});
    wr(8'h00, 32'h00FF_0000);
    wr(cfg_a(0), 32'h20); wr(cfg_a(2), 32'h08); @(negedge clk);
    chk("R4 mode bits", {24'h0, pwm_out}, {24'h0, exp_out(8'hA5, 8'h0F, 8'h00, 8'hFF, 8'hFA)});
    wr(cfg_a(0), 32'h28); wr(cfg_a(2), 32'h28); wr(8'h70, 32'h0);

    // R10 restart to start value
    wr(8'h4C, 32'h7); wr(8'h04, 32'h1234);
    rd(8'h04, v); chk("R10 restart at start", v, 32'h7);

    // R2 tick sources and prescale
    wr(8'h4C, 32'h0); wr(8'h08, 32'h3E8);
    wr(8'h00, 32'h00FF_0008); wr(8'h04, 32'h0);
    rd(8'h04, v); repeat (9) @(negedge clk); rd(8'h04, v2);
    chk("R2 system rate", v2 - v, 32'd10);
    wr(8'h00, 32'h00FF_000A); wr(8'h04, 32'h0);
    rd(8'h04, v); repeat (39) @(negedge clk); rd(8'h04, v2);
    chk("R2 prescale 4", v2 - v, 32'd10);
    fix_per = 3;
    wr(8'h00, 32'h00FF_0010); wr(8'h04, 32'h0);
    rd(8'h04, v); repeat (29) @(negedge clk); rd(8'h04, v2);
    chk("R2 fixed source", v2 - v, 32'd10);
    fix_per = 0; ext_per = 5;
    wr(8'h00, 32'h00FF_0018); wr(8'h04, 32'h0);
    rd(8'h04, v); repeat (49) @(negedge clk); rd(8'h04, v2);
    chk("R2 external source", v2 - v, 32'd10);
    ext_per = 0;

    // R3 reload sequence
    wr(8'h4C, 32'h2); wr(8'h08, 32'h9);
    wr(8'h00, 32'h00FF_0008); wr(8'h04, 32'h0);
    rd(8'h04, v);
    chk("R3 in range", {31'h0, (v >= 2 && v <= 9)}, 32'h1);
    for (int i = 0; i < 24; i++) begin
      rd(8'h04, v2);
      chk("R3 reload step", v2, (v == 9) ? 32'h2 : v + 1);
      v = v2;
    end

    // R3 R4 R5 random duty over whole periods
    for (int k = 0; k < 40; k++) begin
      int start, top, cmp, ps, ch, per, hi, exp;
      logic pol;
      start = int'($urandom % 3);
      top   = start + 2 + int'($urandom % 30);
      cmp   = int'($urandom % (top + 4));
      ps    = int'($urandom % 3);
      ch    = int'($urandom % 8);
      pol   = 1'($urandom % 2);
      if (k == 0) cmp = 0;
      if (k == 1) cmp = top + 1;
      if (k == 2) cmp = start;
      per = (top + 1 - start) << ps;
      wr(8'h4C, 32'(start)); wr(8'h08, 32'(top));
      wr(cmp_a(ch), 32'(cmp)); wr(cfg_a(ch), 32'h28);
      wr(8'h70, 32'(pol) << ch);
      wr(8'h60, $urandom & ~(32'h1 << ch));
      wr(8'h00, 32'h00FF_0008 | 32'(ps));
      wr(8'h04, 32'h0);
      repeat (2 * per) @(negedge clk);
      hi = 0;
      repeat (4 * per) begin
        @(negedge clk);
        hi += int'(pwm_out[ch]);
      end
      exp = 4 * exp_high(cmp, top, start, ps);
      if (pol) exp = 4 * per - exp;
      chk($sformatf("R3 R4 R5 duty ch%0d cmp%0d", ch, cmp), 32'(hi), 32'(exp));
    end

    // R11 stop while running
    wr(8'h00, 32'h00FF_0000);
    rd(8'h04, v); v2 = {24'h0, pwm_out};
    repeat (30) @(negedge clk);
    chk("R11 output frozen", {24'h0, pwm_out}, v2);
    rd(8'h04, v2); chk("R11 counter frozen", v2, v);

    // R9 re-arm, R8 dropped write
    rd(8'h08, v);
    wr(8'h74, 32'h40);
    rd(8'h74, v2); chk("R9 re-armed", v2, 32'h40);
    wr(8'h08, 32'h55);
    rd(8'h08, v2); chk("R8 top dropped", v2, v);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule